// File: doc/BRIEF.md
# Register Rename Map Table

This block keeps the alias table for one class of registers in an out-of-order core. Each architectural register index maps to a physical register tag. A free list of physical tags is built into the block. A rename request for a destination index does three things in the cycle it is accepted: it takes the oldest free tag, installs that tag as the new mapping, and returns both the new tag and the tag it displaced. The displaced tag can be released at commit. Source operands are translated through combinational lookup ports. A rollback port writes an arbitrary tag into an arbitrary slot so that squash logic can undo speculative mappings. A push port returns released tags to the free list, and the current number of free tags is always visible.

The rename interface is valid/ready. The response (`ren_new_tag`, `ren_old_tag`) is combinational and is meaningful in any cycle where `ren_valid` and `ren_ready` are both high; the transfer happens at that clock edge. `ren_ready` drops only when the free list is empty and the request does not name the zero register. While it is low, the requester holds the request and no state changes.

One index may be configured as a hardwired zero register. It stays mapped but is read-only. Setting `ZERO_IDX` to `NUM_ARCH` or above disables it. The tag-release and rollback ports are plain strobes with no back-pressure. `NUM_ARCH` and `NUM_PHYS` must be powers of two with `NUM_PHYS > NUM_ARCH`.

Top module: `rename_map_table`

## Requirements
- R1: After reset, index i maps to tag i, `free_count` equals NUM_PHYS-NUM_ARCH, and the free list hands out tags NUM_ARCH, NUM_ARCH+1, ... in ascending order.
- R2: While a rename of a non-zero index is accepted (`ren_valid` and `ren_ready` high), `ren_new_tag` shows the oldest free tag and `ren_old_tag` the index's current mapping. After the edge, the index maps to the new tag.
- R3: Each accepted non-zero rename lowers `free_count` by one at the following edge, and each accepted push raises it by one.
- R4: With `free_count` at 0, a rename of any non-zero index sees `ren_ready` low and changes neither the table nor the count.
- R5: A rename naming `ZERO_IDX` is always ready. It reports the existing mapping as both the new and the previous tag, takes no free tag, and leaves the table unchanged.
- R6: Each lookup port returns the tag mapped to its index before the clock edge. A lookup of an index being renamed in the same cycle returns the old tag.
- R7: `set_valid` writes `set_tag` into slot `set_arch` at the edge. If a rename targets the same slot in that cycle, the rollback value wins. A rollback naming `ZERO_IDX` is ignored.
- R8: A `free_valid` pulse appends `free_tag` behind all tags already free, so tags come back out in first-in first-out order. It never alters the table, and a push made while `free_count` equals NUM_PHYS is dropped.
- R9: A rename and a push accepted in the same cycle leave `free_count` unchanged. The rename takes the old head, and the pushed tag joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename can be accepted this cycle (low = stall) |
| ren_arch | input | ARCH_W | Destination architectural index |
| ren_new_tag | output | TAG_W | Tag being assigned |
| ren_old_tag | output | TAG_W | Tag displaced by the rename |
| lk_arch | input | NUM_SRC*ARCH_W | Lookup indices, port s in bits s*ARCH_W upward |
| lk_tag | output | NUM_SRC*TAG_W | Lookup results, port s in bits s*TAG_W upward |
| set_valid | input | 1 | Rollback write strobe |
| set_arch | input | ARCH_W | Rollback slot |
| set_tag | input | TAG_W | Rollback tag |
| free_valid | input | 1 | Tag release strobe |
| free_tag | input | TAG_W | Released tag |
| free_count | output | CNT_W | Number of free tags |

## Verification
The bench targets the edges of the free list. It drains the list to empty, where a design that ignored emptiness would hand out stale tags or wrap the count. It fills the list to full, where a design that accepted the extra push would overwrite the head. It also performs a simultaneous push and pop, where a wrong count update would drift by one. It renames the zero register, both normally and with an empty list: a design that treated it as an ordinary index would consume a tag or stall. It also collides rollback, rename and lookup on one index in a single cycle, which would expose the wrong write priority or a lookup that forwards the new tag. A long random phase is compared against a queue-based model on every clock.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  // Source of the next value of one table slot.
  typedef enum logic [1:0] {
    WR_HOLD     = 2'd0,
    WR_RENAME   = 2'd1,
    WR_ROLLBACK = 2'd2
  } rmap_wr_e;

  function automatic bit rmap_is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/rmap_free_list.sv
module rmap_free_list
  import rmap_pkg::*;
#(
  parameter int NUM_PHYS = 64,
  parameter int NUM_ARCH = 32,
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W     = TAG_W;
  localparam int NUM_FREE0 = NUM_PHYS - NUM_ARCH;

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [TAG_W-1:0] slot [NUM_PHYS];
  logic             push_ok;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W'(NUM_PHYS));
  assign push_ok = push && !full;

  for (genvar s = 0; s < NUM_PHYS; s++) begin : g_slot
    localparam logic [PTR_W-1:0] SLOT_ID = PTR_W'(s);
    localparam int INIT_TAG = (s < NUM_FREE0) ? (NUM_ARCH + s) : 0;
    logic [TAG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q <= TAG_W'(INIT_TAG);
      else if (push_ok && tail_q == SLOT_ID) q <= push_tag;
    end
    assign slot[s] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= PTR_W'(NUM_FREE0);
      count_q <= CNT_W'(NUM_FREE0);
    end else begin
      if (pop)     head_q <= head_q + 1'b1;
      if (push_ok) tail_q <= tail_q + 1'b1;
      case ({push_ok, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_tag = slot[head_q];
  assign count    = count_q;
endmodule

// File: rtl/rmap_table.sv
module rmap_table
  import rmap_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int ARCH_W   = 5,
  parameter int TAG_W    = 6,
  parameter int NUM_SRC  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ren_we,
  input  logic [ARCH_W-1:0]         ren_idx,
  input  logic [TAG_W-1:0]          ren_tag,
  input  logic                      rb_we,
  input  logic [ARCH_W-1:0]         rb_idx,
  input  logic [TAG_W-1:0]          rb_tag,
  input  logic [ARCH_W-1:0]         dst_idx,
  output logic [TAG_W-1:0]          dst_tag,
  input  logic [NUM_SRC*ARCH_W-1:0] src_idx,
  output logic [NUM_SRC*TAG_W-1:0]  src_tag
);
  logic [TAG_W-1:0] tbl [NUM_ARCH];

  for (genvar e = 0; e < NUM_ARCH; e++) begin : g_ent
    localparam logic [ARCH_W-1:0] ENT_ID = ARCH_W'(e);
    logic [TAG_W-1:0] q;
    rmap_wr_e         sel;
    always_comb begin
      if (rb_we && rb_idx == ENT_ID)        sel = WR_ROLLBACK;
      else if (ren_we && ren_idx == ENT_ID) sel = WR_RENAME;
      else                                  sel = WR_HOLD;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= TAG_W'(e);
      else begin
        case (sel)
          WR_ROLLBACK: q <= rb_tag;
          WR_RENAME:   q <= ren_tag;
          default:     q <= q;
        endcase
      end
    end
    assign tbl[e] = q;
  end

  assign dst_tag = tbl[dst_idx];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_tag[s*TAG_W +: TAG_W] = tbl[src_idx[s*ARCH_W +: ARCH_W]];
  end
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rmap_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int ZERO_IDX = 0,
  parameter int NUM_SRC  = 2,
  parameter int ARCH_W   = $clog2(NUM_ARCH),
  parameter int TAG_W    = $clog2(NUM_PHYS),
  parameter int CNT_W    = $clog2(NUM_PHYS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ren_valid,
  output logic                      ren_ready,
  input  logic [ARCH_W-1:0]         ren_arch,
  output logic [TAG_W-1:0]          ren_new_tag,
  output logic [TAG_W-1:0]          ren_old_tag,
  input  logic [NUM_SRC*ARCH_W-1:0] lk_arch,
  output logic [NUM_SRC*TAG_W-1:0]  lk_tag,
  input  logic                      set_valid,
  input  logic [ARCH_W-1:0]         set_arch,
  input  logic [TAG_W-1:0]          set_tag,
  input  logic                      free_valid,
  input  logic [TAG_W-1:0]          free_tag,
  output logic [CNT_W-1:0]          free_count
);
  localparam bit HAS_ZERO = (ZERO_IDX >= 0) && (ZERO_IDX < NUM_ARCH);
  localparam logic [ARCH_W-1:0] ZERO_A = HAS_ZERO ? ARCH_W'(ZERO_IDX) : '0;

  initial begin
    if (!rmap_is_pow2(NUM_ARCH) || !rmap_is_pow2(NUM_PHYS) || NUM_PHYS <= NUM_ARCH)
      $error("rename_map_table: sizes must be powers of two with NUM_PHYS > NUM_ARCH");
  end

  logic             ren_is_zero, set_is_zero;
  logic             alloc, rb_ok;
  logic             fl_empty, fl_full;
  logic [TAG_W-1:0] fl_head, cur_tag;

  assign ren_is_zero = HAS_ZERO && (ren_arch == ZERO_A);
  assign set_is_zero = HAS_ZERO && (set_arch == ZERO_A);
  assign ren_ready   = ren_is_zero || !fl_empty;
  assign alloc       = ren_valid && ren_ready && !ren_is_zero;
  assign rb_ok       = set_valid && !set_is_zero;

  assign ren_old_tag = cur_tag;
  assign ren_new_tag = ren_is_zero ? cur_tag : fl_head;

  rmap_free_list #(
    .NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .push(free_valid), .push_tag(free_tag),
    .head_tag(fl_head), .count(free_count),
    .empty(fl_empty), .full(fl_full)
  );

  rmap_table #(
    .NUM_ARCH(NUM_ARCH), .ARCH_W(ARCH_W), .TAG_W(TAG_W), .NUM_SRC(NUM_SRC)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .ren_we(alloc), .ren_idx(ren_arch), .ren_tag(fl_head),
    .rb_we(rb_ok), .rb_idx(set_arch), .rb_tag(set_tag),
    .dst_idx(ren_arch), .dst_tag(cur_tag),
    .src_idx(lk_arch), .src_tag(lk_tag)
  );

  logic unused_full;
  assign unused_full = fl_full;
endmodule

// File: rtl/rmap_checker.sv
module rmap_checker #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int ZERO_IDX = 0,
  parameter int ARCH_W   = 5,
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ren_valid,
  input logic              ren_ready,
  input logic [ARCH_W-1:0] ren_arch,
  input logic [TAG_W-1:0]  ren_new_tag,
  input logic [TAG_W-1:0]  ren_old_tag,
  input logic              free_valid,
  input logic [CNT_W-1:0]  free_count
);
  logic zero_req;
  assign zero_req = (ZERO_IDX >= 0) && (ZERO_IDX < NUM_ARCH) &&
                    (int'(ren_arch) == ZERO_IDX);

  assert_stall_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !zero_req && free_count == '0) |-> !ren_ready);

  assert_stall_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_ready && !free_valid) |=> $stable(free_count));

  assert_rename_pops_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && !zero_req && !free_valid)
      |=> (int'(free_count) == int'($past(free_count)) - 1));

  assert_zero_reg_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && zero_req) |-> (ren_ready && ren_new_tag == ren_old_tag));

  assert_zero_reg_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && zero_req && !free_valid) |=> $stable(free_count));

  assert_push_pop_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && !zero_req && free_valid && int'(free_count) != NUM_PHYS)
      |=> $stable(free_count));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_count) <= NUM_PHYS);
endmodule

bind rename_map_table rmap_checker #(
  .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .ZERO_IDX(ZERO_IDX),
  .ARCH_W(ARCH_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_rmap_checker (
  .clk(clk), .rst_n(rst_n),
  .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_arch(ren_arch),
  .ren_new_tag(ren_new_tag), .ren_old_tag(ren_old_tag),
  .free_valid(free_valid), .free_count(free_count)
);

// File: tb/test_rename_map_table.sv
module test_rename_map_table;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int ZI = 0;
  localparam int NS = 2;
  localparam int AW = 3;
  localparam int TW = 4;
  localparam int CW = 5;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             ren_valid = 1'b0;
  logic             ren_ready;
  logic [AW-1:0]    ren_arch = '0;
  logic [TW-1:0]    ren_new_tag, ren_old_tag;
  logic [NS*AW-1:0] lk_arch = '0;
  logic [NS*TW-1:0] lk_tag;
  logic             set_valid = 1'b0;
  logic [AW-1:0]    set_arch = '0;
  logic [TW-1:0]    set_tag = '0;
  logic             free_valid = 1'b0;
  logic [TW-1:0]    free_tag = '0;
  logic [CW-1:0]    free_count;

  rename_map_table #(.NUM_ARCH(NA), .NUM_PHYS(NP), .ZERO_IDX(ZI), .NUM_SRC(NS)) i_rename_map_table (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_arch(ren_arch),
    .ren_new_tag(ren_new_tag), .ren_old_tag(ren_old_tag),
    .lk_arch(lk_arch), .lk_tag(lk_tag),
    .set_valid(set_valid), .set_arch(set_arch), .set_tag(set_tag),
    .free_valid(free_valid), .free_tag(free_tag), .free_count(free_count)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int mdl_map [NA];
  int mdl_fl [$];
  int got_new, got_old, got_rdy, got_cnt, got_lk0, got_lk1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, WATCHDOG);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // One clock: drive at the falling edge, compare against the model, advance the model.
  task automatic cyc(input bit rv, input int ra, input bit sv, input int sa, input int st,
                     input bit fv, input int ft, input int l0, input int l1);
    bit ezero, erdy;
    int pre;
    @(negedge clk);
    ren_valid = rv;  ren_arch = AW'(ra);
    set_valid = sv;  set_arch = AW'(sa); set_tag = TW'(st);
    free_valid = fv; free_tag = TW'(ft);
    lk_arch = {AW'(l1), AW'(l0)};
    #1;
    ezero = (ra == ZI);
    erdy  = ezero || (mdl_fl.size() > 0);
    got_new = int'(ren_new_tag); got_old = int'(ren_old_tag);
    got_rdy = int'(ren_ready);   got_cnt = int'(free_count);
    got_lk0 = int'(lk_tag[TW-1:0]); got_lk1 = int'(lk_tag[2*TW-1:TW]);
    chk("R3 free_count", got_cnt, mdl_fl.size());
    chk("R6 lookup0", got_lk0, mdl_map[l0]);
    chk("R6 lookup1", got_lk1, mdl_map[l1]);
    if (rv) begin
      chk("R4 ren_ready", got_rdy, int'(erdy));
      if (erdy) begin
        chk("R2 old tag", got_old, mdl_map[ra]);
        chk("R2 new tag", got_new, ezero ? mdl_map[ra] : mdl_fl[0]);
      end
    end
    @(posedge clk);
    pre = mdl_fl.size();
    if (rv && erdy && !ezero) mdl_map[ra] = mdl_fl.pop_front();
    if (sv && sa != ZI) mdl_map[sa] = st;
    if (fv && pre < NP) mdl_fl.push_back(ft);
  endtask

  task automatic idle(input int l0, input int l1);
    cyc(0, 1, 0, 1, 0, 0, 0, l0, l1);
  endtask

  initial begin
    for (int i = 0; i < NA; i++) mdl_map[i] = i;
    for (int t = NA; t < NP; t++) mdl_fl.push_back(t);
    #23 rst_n = 1'b1;

    // R1: reset mapping and count
    for (int i = 0; i < NA; i++) begin
      idle(i, NA - 1 - i);
      chk("R1 reset map", got_lk0, i);
    end
    chk("R1 reset count", got_cnt, NP - NA);

    // R2/R6: rename with a same-cycle lookup of the same index
    cyc(1, 3, 0, 0, 0, 0, 0, 3, 3);
    chk("R2 first new tag", got_new, 8);
    chk("R1 first tag ascending", got_old, 3);
    chk("R6 lookup sees old tag", got_lk0, 3);
    cyc(1, 3, 0, 0, 0, 0, 0, 3, 0);
    chk("R2 chained rename new", got_new, 9);
    chk("R2 chained rename old", got_old, 8);

    // R5: zero register
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 3);
    chk("R5 zero ready", got_rdy, 1);
    chk("R5 zero new=old", got_new, 0);
    idle(0, 3);
    chk("R5 zero count kept", got_cnt, 6);
    chk("R5 zero map kept", got_lk0, 0);

    // R7: rollback, rollback of the zero slot, rollback vs rename collision
    cyc(0, 1, 1, 3, 3, 0, 0, 3, 0);
    cyc(0, 1, 1, 0, 12, 0, 0, 3, 0);
    chk("R7 rollback written", got_lk0, 3);
    cyc(1, 4, 1, 4, 4, 0, 0, 0, 4);
    chk("R7 zero slot ignored", got_lk0, 0);
    chk("R2 rename under rollback", got_new, 10);
    idle(4, 0);
    chk("R7 rollback wins", got_lk0, 4);

    // R8: pushes append, table untouched
    cyc(0, 1, 0, 0, 0, 1, 9, 3, 5);
    cyc(0, 1, 0, 0, 0, 1, 10, 3, 5);
    chk("R8 push count", got_cnt, 6);
    chk("R8 table untouched", got_lk0, 3);
    for (int k = 1; k < NA; k++) begin
      cyc(1, k, 0, 0, 0, 0, 0, k, 0);
      if (k == 6) chk("R8 fifo order a", got_new, 9);
      if (k == 7) chk("R8 fifo order b", got_new, 10);
    end

    // R4: empty list stalls, zero register still accepted
    cyc(1, 2, 0, 0, 0, 0, 0, 2, 0);
    chk("R4 stall ready", got_rdy, 0);
    chk("R4 empty count", got_cnt, 0);
    idle(2, 0);
    chk("R4 stall leaves map", got_lk0, 12);
    chk("R4 stall leaves count", got_cnt, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 zero ready when empty", got_rdy, 1);

    // R9: push and pop together
    cyc(1, 6, 0, 0, 0, 1, 5, 6, 0);
    chk("R4 push while empty still stalls", got_rdy, 0);
    cyc(1, 6, 0, 0, 0, 1, 7, 6, 0);
    chk("R9 pop takes head", got_new, 5);
    idle(6, 0);
    chk("R9 count balanced", got_cnt, 1);
    cyc(1, 1, 0, 0, 0, 0, 0, 6, 0);
    chk("R9 pushed tag at tail", got_new, 7);

    // R8: fill to full, extra pushes dropped
    for (int t = 0; t < NP + 3; t++) cyc(0, 1, 0, 0, 0, 1, t % NP, 0, 0);
    idle(0, 0);
    chk("R8 full count", got_cnt, NP);
    cyc(1, 5, 0, 0, 0, 1, 9, 5, 0);
    chk("R8 head survives overflow", got_new, 0);

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      cyc(($urandom % 4) != 0, $urandom % NA,
          ($urandom % 6) == 0, $urandom % NA, $urandom % NP,
          ($urandom % 3) == 0, $urandom % NP,
          $urandom % NA, $urandom % NA);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule